// File: doc/BRIEF.md
# Windowed Lazy Match Selector

This block sits between a parallel match finder and an entropy coder in a compressor that handles several input bytes per clock. Each cycle it may take one window of `PWS` consecutive stream positions. For each position the window holds the byte at that position and the best match the finder produced there (a length and a backward distance). The block decides which positions become literal tokens, which become match tokens, and which are covered by an earlier match and so produce nothing. The decisions for a window appear on the outputs one clock after the window is accepted.

Inside a window the choice is lazy. A match is held back while the next position offers a longer one. A window can also end partway through a match, so the block settles that case first. It finds the earliest uncovered position whose match runs past the end of the window and commits that match at full length. It carries the covered remainder into the following windows. Only after that does it make the lazy choices for the positions before the committed match, clipping their matches so that they stop where it begins.

The final window of a stream is marked and gives its count of valid positions. In that window matches are clipped to the end of the data and nothing is carried forward. The last token of the stream is flagged.

Top module: `lz_window_selector`

## Requirements
- R1: After reset `out_valid`, `out_done` and every lane of `out_tok_valid` and `out_tok_last` are 0, and the first window of the stream starts with no covered positions.
- R2: A window accepted with `in_valid` high appears one cycle later with `out_valid` high. Lane k of the outputs describes stream position base+k. Lane k's byte is at bits [8k+7:8k], its length at [LEN_W*k+LEN_W-1:LEN_W*k] and its distance at [DIST_W*k+DIST_W-1:DIST_W*k]. With `out_valid` low, no lane is valid.
- R3: A position whose usable match length is below `MIN_MATCH` (default 4) gives a literal token (`out_tok_match`=0) carrying its byte.
- R4: When a position could start a match but the next position in the same decision region has a strictly longer usable match, the position gives a literal, and the same test repeats at the next position.
- R5: Otherwise the position gives a match token with its usable length and its distance, and the positions it covers give no token.
- R6: In a window that is not final, the earliest uncovered position whose match length is at least `MIN_MATCH` and reaches past the window end is committed as a match at full length. Matches at earlier positions are clipped to end at that position, and a clip below `MIN_MATCH` turns the position into a literal.
- R7: Positions covered by a match committed in an earlier window give no token. Such a match may cover whole windows.
- R8: In a window with `in_last`=1, only lanes below `in_count` are used and matches are clipped to end at `in_count`. The next stream starts with no covered positions.
- R9: In the final window the highest valid lane alone has `out_tok_last`=1, and `out_done` is 1 with that window's `out_valid`.
- R10: Replaying the tokens in order rebuilds the input byte stream exactly. A literal appends its byte. A match of length L and distance D copies L bytes, one at a time, from D bytes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A window is presented this cycle |
| in_last | input | 1 | The window ends the stream |
| in_count | input | IDX_W | Valid positions in the final window (1..PWS) |
| in_lit | input | PWS*8 | Byte at each position |
| in_len | input | PWS*LEN_W | Match length found at each position |
| in_dist | input | PWS*DIST_W | Match distance found at each position |
| out_valid | output | 1 | Decisions for one window are present |
| out_done | output | 1 | This window ends the stream |
| out_tok_valid | output | PWS | Lane carries a token |
| out_tok_match | output | PWS | 1 = match token, 0 = literal |
| out_tok_last | output | PWS | Final token of the stream |
| out_lit | output | PWS*8 | Literal byte per lane |
| out_len | output | PWS*LEN_W | Match length per lane |
| out_dist | output | PWS*DIST_W | Match distance per lane |

## Verification
The bench builds streams from small alphabets so that real matches are dense. It includes long runs of one byte, whose matches cover several whole windows. A selector that dropped the carry would emit tokens for covered bytes, and the rebuilt stream would grow too long. A selector that let an earlier match run over the committed crossing match would give overlapping tokens, and the rebuild would go wrong. Lazy ordering is tested wherever a longer match follows a shorter one: a greedy selector gives a different token sequence from the expected one. Unused lanes of the final window are filled with nonzero lengths, so a selector that ignored the count would emit matches past the end.

// File: rtl/lzsel_pkg.sv
package lzsel_pkg;
   typedef enum logic [1:0] {
      TK_NONE  = 2'd0,
      TK_LIT   = 2'd1,
      TK_MATCH = 2'd2
   } tok_kind_e;
endpackage

// File: rtl/lzsel_cross.sv
module lzsel_cross #(
   parameter int PWS       = 4,
   parameter int LEN_W     = 8,
   parameter int MIN_MATCH = 4,
   localparam int IDX_W    = $clog2(PWS + 1),
   localparam int SUM_W    = LEN_W + 2
) (
   input  logic [LEN_W-1:0]     skip_i,
   input  logic                 last_i,
   input  logic [PWS*LEN_W-1:0] len_i,
   output logic                 found_o,
   output logic [IDX_W-1:0]     pos_o,
   output logic [LEN_W-1:0]     carry_o
);
   logic [LEN_W-1:0] ln;

   always_comb begin
      found_o = 1'b0;
      pos_o   = IDX_W'(PWS);
      carry_o = '0;
      ln      = '0;
      if (!last_i) begin
         if (SUM_W'(skip_i) > SUM_W'(PWS))
            carry_o = LEN_W'(SUM_W'(skip_i) - SUM_W'(PWS));
         // descending scan: the lowest qualifying position wins
         for (int i = PWS - 1; i >= 0; i--) begin
            ln = len_i[i*LEN_W +: LEN_W];
            if (SUM_W'(i) >= SUM_W'(skip_i) && SUM_W'(ln) >= SUM_W'(MIN_MATCH) &&
                SUM_W'(i) + SUM_W'(ln) > SUM_W'(PWS)) begin
               found_o = 1'b1;
               pos_o   = IDX_W'(i);
               carry_o = LEN_W'(SUM_W'(i) + SUM_W'(ln) - SUM_W'(PWS));
            end
         end
      end
   end
endmodule

// File: rtl/lzsel_clip.sv
module lzsel_clip #(
   parameter int PWS    = 4,
   parameter int LEN_W  = 8,
   localparam int IDX_W = $clog2(PWS + 1),
   localparam int SUM_W = LEN_W + 2
) (
   input  logic [IDX_W-1:0]     stop_i,
   input  logic [PWS*LEN_W-1:0] len_i,
   output logic [PWS*LEN_W-1:0] eff_o
);
   for (genvar g = 0; g < PWS; g++) begin : g_lane
      logic [LEN_W-1:0] raw;
      logic [SUM_W-1:0] room;
      assign raw  = len_i[g*LEN_W +: LEN_W];
      assign room = (stop_i > IDX_W'(g)) ? SUM_W'(stop_i) - SUM_W'(g) : '0;
      assign eff_o[g*LEN_W +: LEN_W] = (SUM_W'(raw) > room) ? LEN_W'(room) : raw;
   end
endmodule

// File: rtl/lzsel_lazy.sv
module lzsel_lazy
   import lzsel_pkg::*;
#(
   parameter int PWS       = 4,
   parameter int LEN_W     = 8,
   parameter int MIN_MATCH = 4,
   localparam int IDX_W    = $clog2(PWS + 1),
   localparam int SUM_W    = LEN_W + 2
) (
   input  logic [LEN_W-1:0]     skip_i,
   input  logic [IDX_W-1:0]     stop_i,
   input  logic                 found_i,
   input  logic [IDX_W-1:0]     pos_i,
   input  logic [PWS*LEN_W-1:0] eff_i,
   input  logic [PWS*LEN_W-1:0] raw_i,
   output logic [2*PWS-1:0]     kind_o,
   output logic [PWS*LEN_W-1:0] tlen_o
);
   logic [(PWS+1)*LEN_W-1:0] eff_pad;
   logic [SUM_W-1:0]         busy;
   logic [LEN_W-1:0]         cur;
   logic [LEN_W-1:0]         nxt;

   assign eff_pad = {{LEN_W{1'b0}}, eff_i};

   always_comb begin
      busy   = SUM_W'(skip_i);
      kind_o = '0;
      tlen_o = '0;
      cur    = '0;
      nxt    = '0;
      for (int i = 0; i < PWS; i++) begin
         cur = eff_pad[i*LEN_W +: LEN_W];
         nxt = eff_pad[(i+1)*LEN_W +: LEN_W];
         if (SUM_W'(i) >= busy) begin
            if (found_i && IDX_W'(i) == pos_i) begin
               kind_o[2*i +: 2]       = TK_MATCH;
               tlen_o[i*LEN_W +: LEN_W] = raw_i[i*LEN_W +: LEN_W];
               busy                   = '1;
            end else if (IDX_W'(i) < stop_i) begin
               if (SUM_W'(cur) < SUM_W'(MIN_MATCH)) begin
                  kind_o[2*i +: 2] = TK_LIT;
               end else if (IDX_W'(i + 1) < stop_i && nxt > cur) begin
                  kind_o[2*i +: 2] = TK_LIT;   // defer: a longer match follows
               end else begin
                  kind_o[2*i +: 2]       = TK_MATCH;
                  tlen_o[i*LEN_W +: LEN_W] = cur;
                  busy                   = SUM_W'(i) + SUM_W'(cur);
               end
            end
         end
      end
   end
endmodule

// File: rtl/lz_window_selector.sv
module lz_window_selector
   import lzsel_pkg::*;
#(
   parameter int PWS       = 4,
   parameter int LEN_W     = 8,
   parameter int DIST_W    = 12,
   parameter int MIN_MATCH = 4,
   localparam int IDX_W    = $clog2(PWS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  in_last,
   input  logic [IDX_W-1:0]      in_count,
   input  logic [PWS*8-1:0]      in_lit,
   input  logic [PWS*LEN_W-1:0]  in_len,
   input  logic [PWS*DIST_W-1:0] in_dist,
   output logic                  out_valid,
   output logic                  out_done,
   output logic [PWS-1:0]        out_tok_valid,
   output logic [PWS-1:0]        out_tok_match,
   output logic [PWS-1:0]        out_tok_last,
   output logic [PWS*8-1:0]      out_lit,
   output logic [PWS*LEN_W-1:0]  out_len,
   output logic [PWS*DIST_W-1:0] out_dist
);
   if (PWS < 2) begin : g_chk_pws
      $error("lz_window_selector: PWS must be at least 2");
   end
   if (MIN_MATCH < 2) begin : g_chk_min
      $error("lz_window_selector: MIN_MATCH must be at least 2");
   end
   if ((1 << LEN_W) <= 2 * PWS) begin : g_chk_len
      $error("lz_window_selector: LEN_W too narrow for PWS");
   end

   logic [LEN_W-1:0]     carry_q;
   logic                 found;
   logic [IDX_W-1:0]     cross_pos;
   logic [LEN_W-1:0]     carry_nxt;
   logic [IDX_W-1:0]     limit;
   logic [IDX_W-1:0]     stop;
   logic [PWS*LEN_W-1:0] eff_len;
   logic [2*PWS-1:0]     kind;
   logic [PWS*LEN_W-1:0] tok_len;
   logic [PWS-1:0]       lane_last;

   assign limit = in_last ? in_count : IDX_W'(PWS);
   assign stop  = found ? cross_pos : limit;

   lzsel_cross #(.PWS(PWS), .LEN_W(LEN_W), .MIN_MATCH(MIN_MATCH)) u_cross (
      .skip_i (carry_q),
      .last_i (in_last),
      .len_i  (in_len),
      .found_o(found),
      .pos_o  (cross_pos),
      .carry_o(carry_nxt)
   );

   lzsel_clip #(.PWS(PWS), .LEN_W(LEN_W)) u_clip (
      .stop_i(stop),
      .len_i (in_len),
      .eff_o (eff_len)
   );

   lzsel_lazy #(.PWS(PWS), .LEN_W(LEN_W), .MIN_MATCH(MIN_MATCH)) u_lazy (
      .skip_i (carry_q),
      .stop_i (stop),
      .found_i(found),
      .pos_i  (cross_pos),
      .eff_i  (eff_len),
      .raw_i  (in_len),
      .kind_o (kind),
      .tlen_o (tok_len)
   );

   always_comb begin
      logic seen;
      seen      = 1'b0;
      lane_last = '0;
      if (in_last) begin
         for (int i = PWS - 1; i >= 0; i--) begin
            if (!seen && kind[2*i +: 2] != TK_NONE) begin
               lane_last[i] = 1'b1;
               seen         = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         carry_q       <= '0;
         out_valid     <= 1'b0;
         out_done      <= 1'b0;
         out_tok_valid <= '0;
         out_tok_match <= '0;
         out_tok_last  <= '0;
         out_lit       <= '0;
         out_len       <= '0;
         out_dist      <= '0;
      end else begin
         out_valid <= in_valid;
         out_done  <= in_valid && in_last;
         if (in_valid) begin
            carry_q      <= in_last ? '0 : carry_nxt;
            out_tok_last <= lane_last;
            for (int i = 0; i < PWS; i++) begin
               out_tok_valid[i] <= kind[2*i +: 2] != TK_NONE;
               out_tok_match[i] <= kind[2*i +: 2] == TK_MATCH;
               out_lit[i*8 +: 8] <= (kind[2*i +: 2] == TK_LIT) ? in_lit[i*8 +: 8] : 8'd0;
               out_len[i*LEN_W +: LEN_W] <= tok_len[i*LEN_W +: LEN_W];
               out_dist[i*DIST_W +: DIST_W] <= (kind[2*i +: 2] == TK_MATCH) ?
                                               in_dist[i*DIST_W +: DIST_W] : '0;
            end
         end else begin
            out_tok_valid <= '0;
            out_tok_match <= '0;
            out_tok_last  <= '0;
         end
      end
   end

   // R2: no lane is valid without a window on the outputs
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_tok_valid == '0 && !out_done));

   // R9: at most one last flag, and only on a valid lane
   p_single_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_tok_last) && ((out_tok_last & ~out_tok_valid) == '0));

   // R9: a last flag only comes with the end of the stream
   p_last_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_tok_last != '0) |-> out_done);

   // R8: a final window leaves no covered positions behind
   p_carry_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> (carry_q == '0));

   // R7: carried coverage stays untouched between windows
   p_carry_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(carry_q));

   for (genvar g = 0; g < PWS; g++) begin : g_chk_lane
      // R3: a match token never falls below the minimum length
      p_match_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (out_tok_valid[g] && out_tok_match[g]) |->
            (out_len[g*LEN_W +: LEN_W] >= LEN_W'(MIN_MATCH)));
   end
endmodule

// File: tb/lz_window_selector_tb_top.sv
module lz_window_selector_tb_top;
   localparam int PWS    = 4;
   localparam int LEN_W  = 8;
   localparam int DIST_W = 12;
   localparam int MINM   = 4;
   localparam int IDX_W  = $clog2(PWS + 1);
   localparam int MAXN   = 100;
   localparam int MAXL   = 12;
   localparam int WIN    = 64;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  in_valid = 1'b0;
   logic                  in_last = 1'b0;
   logic [IDX_W-1:0]      in_count = '0;
   logic [PWS*8-1:0]      in_lit = '0;
   logic [PWS*LEN_W-1:0]  in_len = '0;
   logic [PWS*DIST_W-1:0] in_dist = '0;
   logic                  out_valid, out_done;
   logic [PWS-1:0]        out_tok_valid, out_tok_match, out_tok_last;
   logic [PWS*8-1:0]      out_lit;
   logic [PWS*LEN_W-1:0]  out_len;
   logic [PWS*DIST_W-1:0] out_dist;

   always #10 clk = ~clk;   // 50 MHz

   lz_window_selector #(.PWS(PWS), .LEN_W(LEN_W), .DIST_W(DIST_W), .MIN_MATCH(MINM)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last), .in_count(in_count),
      .in_lit(in_lit), .in_len(in_len), .in_dist(in_dist), .out_valid(out_valid),
      .out_done(out_done), .out_tok_valid(out_tok_valid), .out_tok_match(out_tok_match),
      .out_tok_last(out_tok_last), .out_lit(out_lit), .out_len(out_len), .out_dist(out_dist)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] data [0:MAXN-1];
   logic [7:0] recon [0:MAXN+2*MAXL];
   int mlen [0:MAXN-1];
   int mdist[0:MAXN-1];
   int rlen;
   bit e_v [0:PWS-1];
   bit e_m [0:PWS-1];
   bit e_l [0:PWS-1];
   int e_len[0:PWS-1];
   int e_d  [0:PWS-1];

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic find_matches(input int n);
      for (int p = 0; p < n; p++) begin
         mlen[p] = 0; mdist[p] = 0;
         for (int d = 1; d <= p && d <= WIN; d++) begin
            int l = 0;
            while (p + l < n && l < MAXL && data[p+l] == data[p-d+l]) l++;
            if (l > mlen[p]) begin mlen[p] = l; mdist[p] = d; end
         end
      end
   endtask

   // expected tokens of one window, written from R3..R9
   task automatic model_window(input int base, input int n, input bit last, inout int carry);
      int e, p, j, c, c2, s;
      for (int i = 0; i < PWS; i++) begin
         e_v[i] = 0; e_m[i] = 0; e_l[i] = 0; e_len[i] = 0; e_d[i] = 0;
      end
      s = carry; j = -1;
      if (!last)
         for (int i = s; i < PWS; i++)
            if (j < 0 && mlen[base+i] >= MINM && i + mlen[base+i] > PWS) j = i;
      e = (j >= 0) ? j : (last ? n : PWS);
      p = s;
      while (p < e) begin
         c = (mlen[base+p] < e - p) ? mlen[base+p] : e - p;
         c2 = 0;
         if (p + 1 < e) c2 = (mlen[base+p+1] < e - p - 1) ? mlen[base+p+1] : e - p - 1;
         if (c < MINM || (p + 1 < e && c2 > c)) begin
            e_v[p] = 1; p++;
         end else begin
            e_v[p] = 1; e_m[p] = 1; e_len[p] = c; e_d[p] = mdist[base+p]; p += c;
         end
      end
      if (j >= 0) begin
         e_v[j] = 1; e_m[j] = 1; e_len[j] = mlen[base+j]; e_d[j] = mdist[base+j];
         carry = j + mlen[base+j] - PWS;
      end else begin
         carry = (!last && s > PWS) ? s - PWS : 0;
      end
      if (last)
         for (int i = PWS - 1; i >= 0; i--)
            if (e_v[i]) begin e_l[i] = 1; break; end
   endtask

   task automatic run_stream(input int n, input string tag);
      int carry = 0;
      int nw = (n + PWS - 1) / PWS;
      rlen = 0;
      find_matches(n);
      for (int w = 0; w < nw; w++) begin
         int base = w * PWS;
         bit last = (w == nw - 1);
         int cnt = last ? n - base : PWS;
         bit ok;
         model_window(base, cnt, last, carry);
         @(negedge clk);
         in_valid = 1; in_last = last; in_count = IDX_W'(cnt);
         for (int i = 0; i < PWS; i++) begin
            if (i < cnt) begin
               in_lit[i*8 +: 8] = data[base+i];
               in_len[i*LEN_W +: LEN_W] = LEN_W'(mlen[base+i]);
               in_dist[i*DIST_W +: DIST_W] = DIST_W'(mdist[base+i]);
            end else begin   // unused lanes of the final window carry junk (R8)
               in_lit[i*8 +: 8] = 8'($urandom);
               in_len[i*LEN_W +: LEN_W] = LEN_W'(5 + $urandom % 6);
               in_dist[i*DIST_W +: DIST_W] = DIST_W'(1 + $urandom % 8);
            end
         end
         @(negedge clk);
         in_valid = 0;
         ok = out_valid;
         for (int i = 0; i < PWS; i++) begin
            if (out_tok_valid[i] != e_v[i] || out_tok_last[i] != e_l[i]) ok = 0;
            if (e_v[i] && out_tok_match[i] != e_m[i]) ok = 0;
            if (e_v[i] && !e_m[i] && out_lit[i*8 +: 8] != data[base+i]) ok = 0;
            if (e_v[i] && e_m[i] && (int'(out_len[i*LEN_W +: LEN_W]) != e_len[i] ||
                                     int'(out_dist[i*DIST_W +: DIST_W]) != e_d[i])) ok = 0;
         end
         check(ok, $sformatf("R2 R3 R4 R5 R6 R7 tokens %s window %0d (valid lanes)", tag, w),
               int'(out_tok_valid), 0);
         if (last)
            check(out_done == 1'b1, $sformatf("R9 done flag %s", tag), int'(out_done), 1);
         else
            check(out_done == 1'b0, $sformatf("R8 early done %s", tag), int'(out_done), 0);
         for (int i = 0; i < PWS; i++) begin
            if (out_tok_valid[i]) begin
               if (!out_tok_match[i]) begin
                  recon[rlen] = out_lit[i*8 +: 8]; rlen++;
               end else begin
                  int d = int'(out_dist[i*DIST_W +: DIST_W]);
                  for (int k = 0; k < int'(out_len[i*LEN_W +: LEN_W]); k++) begin
                     if (rlen - d >= 0 && rlen <= MAXN + MAXL) recon[rlen] = recon[rlen-d];
                     if (rlen <= MAXN + MAXL) rlen++;
                  end
               end
            end
         end
         if ($urandom % 3 == 0) begin
            @(negedge clk);
            check(out_valid == 1'b0 && out_tok_valid == '0, "R2 idle cycle quiet",
                  int'(out_tok_valid), 0);
         end
      end
      begin
         bit same = (rlen == n);
         for (int i = 0; i < n && same; i++) if (recon[i] != data[i]) same = 0;
         check(same, $sformatf("R10 rebuild %s length", tag), rlen, n);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(0, "watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0017));
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && out_tok_valid == '0 && out_tok_last == '0 && out_done == 1'b0,
            "R1 outputs during reset", int'(out_tok_valid), 0);
      rst_n = 1;
      @(negedge clk);
      check(out_valid == 1'b0 && out_done == 1'b0, "R1 outputs after reset", int'(out_valid), 0);
      // directed: long run, carry over whole windows (R7)
      for (int i = 0; i < 23; i++) data[i] = 8'h41;
      run_stream(23, "run");
      // directed: no repeats at all, every position literal (R3)
      for (int i = 0; i < 32; i++) data[i] = 8'(i * 7 + 3);
      run_stream(32, "distinct");
      // directed: single byte stream (R8 R9)
      data[0] = 8'h5a;
      run_stream(1, "single");
      // directed: shorter match followed by a longer one (R4)
      for (int i = 0; i < 40; i++) data[i] = 8'($urandom % 200 + 40);
      for (int i = 0; i < 4; i++) data[10+i] = data[2+i];
      for (int i = 0; i < 9; i++) data[15+i] = data[3+i];
      data[14] = data[2];
      run_stream(40, "lazy");
      // random streams over small alphabets (R5 R6 R10)
      for (int t = 0; t < 40; t++) begin
         int n = 1 + $urandom % MAXN;
         int a = 2 + $urandom % 3;
         for (int i = 0; i < n; i++) data[i] = 8'($urandom % a + 8'h61);
         run_stream(n, $sformatf("rand%0d", t));
      end
      repeat (2) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule